// File: doc/BRIEF.md
# Settable Minutes-Seconds Countdown Timer

This block is a countdown timer core. It keeps a time value as four BCD digits, minutes tens, minutes units, seconds tens and seconds units, and hands them to a display driver as MM.SS. There are two modes. In SET mode, the time can be adjusted. In GO mode, the time counts down once per second. A pulse on the centre button moves between the two modes. Because leaving GO does not clear the seconds, the same button also works as pause and resume.

In SET mode, the up and down pulses move the value to a whole number of minutes, and the seconds always end at 00. Up goes to the next whole minute. Down goes to the current whole minute when the seconds are nonzero, and otherwise removes one minute. The minutes stay between 0 and 60. In GO mode, a prescaler produces a one-second tick from the `CLK_HZ` parameter, which must be 2 or more. The prescaler restarts each time GO is entered. The count stops at 00:00 and the block stays in GO mode.

The button inputs are single-cycle pulses that have already been debounced and edge-detected. Button conditioning and segment driving are handled outside this block.

Top module: `cdt_countdown`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in SET mode (`go_mode`=0) and all four digits read 0.
- R2: Each clock cycle with `btn_mode` high inverts `go_mode` at that clock edge.
- R3: In SET mode, an `btn_up` pulse sets the value to (whole minutes + 1):00, so 12:07 becomes 13:00. At 60 minutes the value saturates at 60:00.
- R4: In SET mode, a `btn_down` pulse with nonzero seconds sets the value to the same minutes with seconds 00. With seconds already 00, it removes one minute. At 00:00 the value stays 00:00.
- R5: If `btn_up` and `btn_down` are high in the same SET-mode cycle, only the up action applies.
- R6: While `go_mode` is 1, `btn_up` and `btn_down` leave the value unchanged.
- R7: In GO mode, the value falls by one second every `CLK_HZ` clock cycles. The first decrement happens at the `CLK_HZ`-th clock edge after the edge that registered the centre pulse.
- R8: A decrement from MM:00 with MM>0 gives (MM-1):59, and the borrow ripples through the minutes digits, so 10:00 becomes 09:59.
- R9: When GO mode reaches 00:00, the value stays 00:00 and `go_mode` stays 1 until the next centre pulse.
- R10: A move from GO to SET keeps the seconds. When GO is entered again, counting continues from the held value.
- R11: Seconds tens is never above 5, the other digits are never above 9, and the minutes are never above 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_mode | input | 1 | Centre-button pulse that toggles between SET and GO |
| btn_up | input | 1 | Up-button pulse, used in SET mode |
| btn_down | input | 1 | Down-button pulse, used in SET mode |
| dig_m10 | output | 4 | Minutes tens digit, BCD |
| dig_m1 | output | 4 | Minutes units digit, BCD |
| dig_s10 | output | 4 | Seconds tens digit, BCD |
| dig_s1 | output | 4 | Seconds units digit, BCD |
| go_mode | output | 1 | 1 in GO mode, 0 in SET mode |

## Verification
A corrupted digit register becomes visible at the ports in the very next cycle, because the digits are driven straight from state. A bad carry or borrow shows up at the first tick that crosses a ten-second or one-minute boundary. A prescaler that is wrong by even one cycle moves every decrement edge. That error is caught during the first second of GO, since the bench compares the value in every cycle against its own integer-seconds model. A stuck or doubled mode toggle shows as a wrong `go_mode` on the cycle after the pulse, and as adjustments that are either applied or ignored against the rules.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef struct packed {
    logic [3:0] m10;
    logic [3:0] m1;
    logic [3:0] s10;
    logic [3:0] s1;
  } cdt_time_t;

  localparam logic [6:0] MAX_MIN = 7'd60;

  function automatic logic [6:0] minutes_of(input cdt_time_t t);
    return 7'(t.m10) * 7'd10 + 7'(t.m1);
  endfunction

  function automatic logic secs_nonzero(input cdt_time_t t);
    return (t.s10 != 4'd0) || (t.s1 != 4'd0);
  endfunction

  function automatic logic is_zero(input cdt_time_t t);
    return (t == '0);
  endfunction

  // next whole minute, saturating at MAX_MIN
  function automatic cdt_time_t bump_minute(input cdt_time_t t);
    cdt_time_t r;
    r = t;
    r.s10 = 4'd0;
    r.s1  = 4'd0;
    if (minutes_of(t) < MAX_MIN) begin
      if (t.m1 == 4'd9) begin
        r.m1  = 4'd0;
        r.m10 = t.m10 + 4'd1;
      end else begin
        r.m1 = t.m1 + 4'd1;
      end
    end
    return r;
  endfunction

  // round down to whole minute, or drop one minute if already whole
  function automatic cdt_time_t drop_minute(input cdt_time_t t);
    cdt_time_t r;
    r = t;
    r.s10 = 4'd0;
    r.s1  = 4'd0;
    if (!secs_nonzero(t) && minutes_of(t) != 7'd0) begin
      if (t.m1 == 4'd0) begin
        r.m1  = 4'd9;
        r.m10 = t.m10 - 4'd1;
      end else begin
        r.m1 = t.m1 - 4'd1;
      end
    end
    return r;
  endfunction

  // one second less, holding at zero
  function automatic cdt_time_t step_second(input cdt_time_t t);
    cdt_time_t r;
    r = t;
    if (t.s1 != 4'd0) begin
      r.s1 = t.s1 - 4'd1;
    end else if (t.s10 != 4'd0) begin
      r.s10 = t.s10 - 4'd1;
      r.s1  = 4'd9;
    end else if (t.m1 != 4'd0) begin
      r.m1  = t.m1 - 4'd1;
      r.s10 = 4'd5;
      r.s1  = 4'd9;
    end else if (t.m10 != 4'd0) begin
      r.m10 = t.m10 - 4'd1;
      r.m1  = 4'd9;
      r.s10 = 4'd5;
      r.s1  = 4'd9;
    end
    return r;
  endfunction

endpackage

// File: rtl/cdt_tick.sv
module cdt_tick #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R7: ticks are isolated single-cycle events (CLK_HZ >= 2)
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R7: prescaler restarts on entry to GO
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> cnt == '0);
endmodule

// File: rtl/cdt_mode.sv
module cdt_mode (
  input  logic clk,
  input  logic rst,
  input  logic toggle,
  output logic go
);
  always_ff @(posedge clk) begin
    if (rst) go <= 1'b0;
    else if (toggle) go <= ~go;
  end

  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    toggle |=> go != $past(go));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !toggle |=> $stable(go));
endmodule

// File: rtl/cdt_time.sv
module cdt_time
  import cdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go,
  input  logic      tick,
  input  logic      up,
  input  logic      down,
  output cdt_time_t value
);
  logic set_up, set_down, count_ev;
  assign set_up   = !go && up;
  assign set_down = !go && down && !up;
  assign count_ev = go && tick && !is_zero(value);

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (set_up) value <= bump_minute(value);
    else if (set_down) value <= drop_minute(value);
    else if (count_ev) value <= step_second(value);
  end

  a_r11_digit_range: assert property (@(posedge clk) disable iff (rst)
    value.s10 <= 4'd5 && value.s1 <= 4'd9 && value.m1 <= 4'd9
    && minutes_of(value) <= MAX_MIN);
  a_r6_ignore_in_go: assert property (@(posedge clk) disable iff (rst)
    (go && !tick) |=> $stable(value));
  a_r9_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (go && is_zero(value)) |=> is_zero(value));
  a_r3_whole_minute: assert property (@(posedge clk) disable iff (rst)
    (!go && (up || down)) |=> !secs_nonzero(value));
  a_r8_borrow: assert property (@(posedge clk) disable iff (rst)
    (count_ev && !secs_nonzero(value)) |=> (value.s10 == 4'd5 && value.s1 == 4'd9));
endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_mode,
  input  logic       btn_up,
  input  logic       btn_down,
  output logic [3:0] dig_m10,
  output logic [3:0] dig_m1,
  output logic [3:0] dig_s10,
  output logic [3:0] dig_s1,
  output logic       go_mode
);
  import cdt_pkg::*;

  logic      go, sec_tick;
  cdt_time_t cur;

  cdt_mode u_mode (.clk(clk), .rst(rst), .toggle(btn_mode), .go(go));

  cdt_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst(rst), .run(go), .tick(sec_tick));

  cdt_time u_time (
    .clk(clk), .rst(rst), .go(go), .tick(sec_tick),
    .up(btn_up), .down(btn_down), .value(cur));

  assign dig_m10 = cur.m10;
  assign dig_m1  = cur.m1;
  assign dig_s10 = cur.s10;
  assign dig_s1  = cur.s1;
  assign go_mode = go;

  // R1: state after reset
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!go_mode && cur == '0));
endmodule

// File: tb/tb_cdt_countdown.sv
module tb_cdt_countdown;
  localparam int PERIOD = 10;
  localparam int HZ = 4;

  typedef struct {
    string tag;
    int    secs;
    bit    go;
  } item_t;

  logic clk = 0, rst = 1, b_mode = 0, b_up = 0, b_down = 0;
  logic [3:0] m10, m1, s10, s1;
  logic gom;

  int checks = 0, fails = 0;
  item_t sb[$];
  int  model_secs = 0;
  bit  model_go = 0;
  int  presc = 0;
  bit  done = 0;

  always #(PERIOD/2) clk = ~clk;

  cdt_countdown #(.CLK_HZ(HZ)) dut (
    .clk(clk), .rst(rst), .btn_mode(b_mode), .btn_up(b_up), .btn_down(b_down),
    .dig_m10(m10), .dig_m1(m1), .dig_s10(s10), .dig_s1(s1), .go_mode(gom));

  // reference model in whole seconds
  task automatic model_edge(input bit c, input bit u, input bit d);
    int mins;
    mins = model_secs / 60;
    if (!model_go) begin
      presc = 0;
      if (u) model_secs = ((mins + 1 > 60) ? 60 : mins + 1) * 60;
      else if (d) begin
        if (model_secs % 60 != 0) model_secs = mins * 60;
        else model_secs = ((mins > 0) ? mins - 1 : 0) * 60;
      end
    end else begin
      if (presc == HZ - 1) begin
        presc = 0;
        if (model_secs > 0) model_secs--;
      end else presc++;
    end
    if (c) model_go = !model_go;
  endtask

  task automatic step(input string tag, input bit c, input bit u, input bit d);
    item_t it;
    @(negedge clk);
    b_mode = c; b_up = u; b_down = d;
    @(posedge clk);
    model_edge(c, u, d);
    it.tag = tag; it.secs = model_secs; it.go = model_go;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0);
  endtask

  // monitor: compare against scoreboard away from the clock edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t e;
      int got;
      e = sb.pop_front();
      got = (int'(m10) * 10 + int'(m1)) * 60 + int'(s10) * 10 + int'(s1);
      checks++;
      if (got != e.secs || gom != e.go || s10 > 5 || s1 > 9 || m1 > 9) begin
        fails++;
        $display("FAIL %s: got %0d%0d.%0d%0d go=%0b, expected %0d:%02d go=%0b",
                 e.tag, m10, m1, s10, s1, gom, e.secs / 60, e.secs % 60, e.go);
      end
    end
  end

  initial begin
    item_t it;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    it.tag = "R1"; it.secs = 0; it.go = 0;
    sb.push_back(it);
    idle("R1", 2);
    repeat (13) step("R3", 0, 1, 0);       // 13:00
    step("R4", 0, 0, 1);                   // 12:00
    repeat (52) step("R3", 0, 1, 0);       // saturate 60:00
    step("R5", 0, 1, 1);                   // up wins, stays 60
    repeat (62) step("R4", 0, 0, 1);       // down to 00:00 and hold
    step("R5", 0, 1, 1);                   // 01:00
    repeat (9) step("R3", 0, 1, 0);        // 10:00
    step("R2", 1, 0, 0);                   // GO
    idle("R8", HZ * 2);                    // 09:58
    step("R6", 0, 1, 0);
    step("R6", 0, 0, 1);
    idle("R7", HZ * 5);
    step("R10", 1, 0, 0);                  // pause
    idle("R10", 6);
    step("R10", 1, 0, 0);                  // resume
    idle("R7", HZ * 3);
    step("R2", 1, 0, 0);                   // SET with nonzero seconds
    step("R4", 0, 0, 1);                   // round down to 09:00
    repeat (8) step("R4", 0, 0, 1);        // 01:00
    step("R2", 1, 0, 0);
    idle("R8", HZ * 3);
    step("R2", 1, 0, 0);
    step("R3", 0, 1, 0);                   // rounds up to 01:00
    step("R4", 0, 0, 1);                   // 00:00
    step("R3", 0, 1, 0);                   // 01:00
    step("R2", 1, 0, 0);
    idle("R9", HZ * 62);                   // reach zero and hold
    step("R2", 1, 0, 0);
    idle("R2", 2);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule